// File: doc/BRIEF.md
# Hash-Rehash Direct-Mapped Cache

A single direct-mapped line array that offers a second placement for each block. A read request first looks at its home line, selected by the low address bits. On a home miss, the block may still sit at its partner line, which is the home index with the top index bit inverted. That line is examined in the next cycle. A flag on each line marks a block that is living at its partner location. When that second probe hits, the two lines trade places, so a block that is used again is found at its home line next time. When both probes miss, one word is fetched from memory into the home line. The block that was displaced from the home line moves to the partner line with its flag inverted, and whatever sat at the partner line is dropped.

Requests, responses and memory fetch requests are valid/ready streams. A request is accepted only when `req_ready` is high, and the block holds one request at a time. A response stays on `rsp_valid`/`rsp_kind`/`rsp_data`, unchanged, until `rsp_ready` is seen high at a clock edge. A fetch request stays on `mem_req_valid`/`mem_req_addr` until `mem_req_ready` is high. The memory answers each accepted fetch with a single `mem_rsp_valid` pulse carrying the word. That pulse is always taken and has no back-pressure.

Top module: `hrcache_top`

## Requirements
- R1: Reset leaves every line invalid, with `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. The first request to any address after reset is a full miss.
- R2: Home hit: the home index is the low IDX_W bits of the address, and a hit there needs a valid line with a clear partner flag and an equal tag. The response has `rsp_kind`=0 and the stored word, and `rsp_valid` rises one clock edge after the edge that accepted the request.
- R3: Partner probe: the partner index is the home index with its most significant bit inverted. It is probed only after a home miss. A hit there needs a valid line with a set partner flag and an equal tag. The response has `rsp_kind`=1, and `rsp_valid` rises three edges after acceptance: home probe, partner probe and swap.
- R4: A block held at its partner location never produces a home hit for an address whose home index is that location, even when the tags are equal.
- R5: After a partner hit, the two lines are exchanged and each moved line has its partner flag inverted. A repeat of the same request then hits at home, and the block that was displaced hits on its partner probe.
- R6: Full miss: one fetch is issued with `mem_req_addr` equal to the request address. After `mem_rsp_valid`, the response has `rsp_kind`=2 and the fetched word, and the new block is placed at its home line.
- R7: Under back-pressure, `rsp_valid`, `rsp_kind` and `rsp_data` hold while `rsp_ready` is low, and `mem_req_valid`/`mem_req_addr` hold while `mem_req_ready` is low. `req_ready` stays low from acceptance until the response is taken.
- R8: On a full miss, a valid occupant of the home line moves to the partner line, and the previous contents of the partner line are discarded, so a later request for them misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Block address of the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_kind | output | 2 | 0 home hit, 1 partner hit, 2 full miss |
| rsp_data | output | DATA_W | Word for the requested address |
| mem_req_valid | output | 1 | Fetch request present |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | ADDR_W | Address to fetch |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying fetched word |
| mem_rsp_data | input | DATA_W | Fetched word |

## Verification
The hardest situations to reach are a partner hit and the case where a block waits at its partner line while a different address maps home to that same line with an equal tag. Each needs a specific sequence of two or three earlier misses. Directed sequences build both cases in turn: one block is filled, then displaced by a second block with the same home index, and then either it or the lookalike address is requested. The random phase then draws addresses from only three tags, so that collisions, swaps and evictions happen often.

// File: rtl/hr_pkg.sv
package hr_pkg;
  typedef enum logic [1:0] {
    KIND_HOME = 2'd0,
    KIND_ALT  = 2'd1,
    KIND_FILL = 2'd2
  } hit_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOME  = 3'd1,
    ST_ALT   = 3'd2,
    ST_SWAP  = 3'd3,
    ST_MREQ  = 3'd4,
    ST_MWAIT = 3'd5,
    ST_RESP  = 3'd6
  } ctrl_state_e;
endpackage

// File: rtl/hr_line_store.sv
module hr_line_store #(
  parameter int IDX_W  = 3,
  parameter int LINE_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [LINE_W-1:0] rd_a_line,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [LINE_W-1:0] rd_b_line,
  input  logic              wr_a_en,
  input  logic [IDX_W-1:0]  wr_a_idx,
  input  logic [LINE_W-1:0] wr_a_line,
  input  logic              wr_b_en,
  input  logic [IDX_W-1:0]  wr_b_idx,
  input  logic [LINE_W-1:0] wr_b_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LINE_W-1:0] lines [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lines[i] <= '0;
      end else if (wr_a_en && wr_a_idx == IDX_W'(i)) begin
        lines[i] <= wr_a_line;
      end else if (wr_b_en && wr_b_idx == IDX_W'(i)) begin
        lines[i] <= wr_b_line;
      end
    end
  end

  assign rd_a_line = lines[rd_a_idx];
  assign rd_b_line = lines[rd_b_idx];

  // R5: a swap or fill touches two different lines, never one line twice
  assert_distinct_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_en && wr_b_en) |-> (wr_a_idx != wr_b_idx));
endmodule

// File: rtl/hr_probe.sv
module hr_probe #(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic [TAG_W+1:0] home_meta,
  input  logic [TAG_W+1:0] alt_meta,
  output logic             home_hit,
  output logic             alt_hit
);
  localparam int V_POS = TAG_W + 1;
  localparam int R_POS = TAG_W;

  assign home_hit = home_meta[V_POS] && !home_meta[R_POS] &&
                    (home_meta[TAG_W-1:0] == look_tag);
  assign alt_hit  = alt_meta[V_POS] && alt_meta[R_POS] &&
                    (alt_meta[TAG_W-1:0] == look_tag);

  // R4: a block lives in exactly one place, so both probes never match at once
  assert_single_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(home_hit && alt_hit));
endmodule

// File: rtl/hr_ctrl.sv
module hr_ctrl
  import hr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [IDX_W-1:0]  home_idx,
  output logic [IDX_W-1:0]  alt_idx,
  output logic [ADDR_W-IDX_W-1:0] look_tag,
  input  logic [ADDR_W-IDX_W+DATA_W+1:0] home_line,
  input  logic [ADDR_W-IDX_W+DATA_W+1:0] alt_line,
  input  logic              home_hit,
  input  logic              alt_hit,
  output logic              wr_a_en,
  output logic [IDX_W-1:0]  wr_a_idx,
  output logic [ADDR_W-IDX_W+DATA_W+1:0] wr_a_line,
  output logic              wr_b_en,
  output logic [IDX_W-1:0]  wr_b_idx,
  output logic [ADDR_W-IDX_W+DATA_W+1:0] wr_b_line
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINE_W = TAG_W + DATA_W + 2;
  localparam int V_POS  = LINE_W - 1;
  localparam int R_POS  = LINE_W - 2;
  localparam logic [IDX_W-1:0]  TOP_MASK = IDX_W'(1) << (IDX_W - 1);
  localparam logic [LINE_W-1:0] R_FLIP   = LINE_W'(1) << R_POS;

  ctrl_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  hit_kind_e         kind_q;
  logic [DATA_W-1:0] data_q;

  assign home_idx = addr_q[IDX_W-1:0];
  assign alt_idx  = home_idx ^ TOP_MASK;
  assign look_tag = addr_q[ADDR_W-1:IDX_W];

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_kind      = kind_q;
  assign rsp_data      = data_q;
  assign mem_req_valid = (state == ST_MREQ);
  assign mem_req_addr  = addr_q;

  always_comb begin
    wr_a_en   = 1'b0;
    wr_a_idx  = home_idx;
    wr_a_line = alt_line ^ R_FLIP;
    wr_b_en   = 1'b0;
    wr_b_idx  = alt_idx;
    wr_b_line = home_line ^ R_FLIP;
    if (state == ST_SWAP) begin
      wr_a_en = 1'b1;
      wr_b_en = 1'b1;
    end else if (state == ST_MWAIT && mem_rsp_valid) begin
      wr_a_en   = 1'b1;
      wr_a_line = {1'b1, 1'b0, look_tag, mem_rsp_data};
      wr_b_en   = home_line[V_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      kind_q <= KIND_HOME;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          state  <= ST_HOME;
        end
        ST_HOME: if (home_hit) begin
          kind_q <= KIND_HOME;
          data_q <= home_line[DATA_W-1:0];
          state  <= ST_RESP;
        end else begin
          state <= ST_ALT;
        end
        ST_ALT: if (alt_hit) begin
          kind_q <= KIND_ALT;
          data_q <= alt_line[DATA_W-1:0];
          state  <= ST_SWAP;
        end else begin
          state <= ST_MREQ;
        end
        ST_SWAP:  state <= ST_RESP;
        ST_MREQ:  if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          kind_q <= KIND_FILL;
          data_q <= mem_rsp_data;
          state  <= ST_RESP;
        end
        ST_RESP:  if (rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R7: a stalled response keeps its contents
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_kind)));

  // R7: a stalled fetch keeps its address
  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2: a home-hit response comes straight out of the home probe
  assert_home_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_kind == KIND_HOME) |-> ($past(state) == ST_HOME));

  // R3: a partner-hit response always follows the swap cycle
  assert_alt_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_kind == KIND_ALT) |-> ($past(state) == ST_SWAP));

  // R6: a fetch is only requested after both probes missed
  assert_fetch_after_probes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> ($past(state) == ST_ALT));
endmodule

// File: rtl/hrcache_top.sv
module hrcache_top #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINE_W = TAG_W + DATA_W + 2;

  logic [IDX_W-1:0]  home_idx, alt_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [LINE_W-1:0] home_line, alt_line;
  logic              home_hit, alt_hit;
  logic              wr_a_en, wr_b_en;
  logic [IDX_W-1:0]  wr_a_idx, wr_b_idx;
  logic [LINE_W-1:0] wr_a_line, wr_b_line;

  hr_line_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(home_idx), .rd_a_line(home_line),
    .rd_b_idx(alt_idx),  .rd_b_line(alt_line),
    .wr_a_en(wr_a_en), .wr_a_idx(wr_a_idx), .wr_a_line(wr_a_line),
    .wr_b_en(wr_b_en), .wr_b_idx(wr_b_idx), .wr_b_line(wr_b_line)
  );

  hr_probe #(.TAG_W(TAG_W)) u_probe (
    .clk(clk), .rst_n(rst_n),
    .look_tag(look_tag),
    .home_meta(home_line[LINE_W-1:DATA_W]),
    .alt_meta(alt_line[LINE_W-1:DATA_W]),
    .home_hit(home_hit), .alt_hit(alt_hit)
  );

  hr_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .home_idx(home_idx), .alt_idx(alt_idx), .look_tag(look_tag),
    .home_line(home_line), .alt_line(alt_line),
    .home_hit(home_hit), .alt_hit(alt_hit),
    .wr_a_en(wr_a_en), .wr_a_idx(wr_a_idx), .wr_a_line(wr_a_line),
    .wr_b_en(wr_b_en), .wr_b_idx(wr_b_idx), .wr_b_line(wr_b_line)
  );
endmodule

// File: tb/sim_hrcache_top.sv
`timescale 1ns/1ps
module sim_hrcache_top;
  localparam int AW = 6;
  localparam int IW = 3;
  localparam int TW = AW - IW;
  localparam int DW = 16;
  localparam int DEPTH = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [1:0] rsp_kind;
  logic [DW-1:0] rsp_data;
  logic mem_req_valid;
  logic mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;

  int checks = 0;
  int fails = 0;
  int mem_reqs = 0;
  logic [AW-1:0] cur_addr = '0;

  bit          mv [DEPTH];
  bit          mr [DEPTH];
  logic [TW-1:0] mt [DEPTH];

  always #2.5 clk = ~clk;

  hrcache_top #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = DW'(a) * 16'h03B5;
    return (w ^ 16'hA5C3) + DW'(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected outcome from the requirements: R2 home, R3 partner, R5 swap, R6/R8 fill
  task automatic predict(input logic [AW-1:0] a, output int k);
    int p, r;
    bit tv, trf;
    logic [TW-1:0] tt;
    p = int'(a[IW-1:0]);
    r = p ^ (1 << (IW - 1));
    if (mv[p] && !mr[p] && mt[p] == a[AW-1:IW]) begin
      k = 0;
    end else if (mv[r] && mr[r] && mt[r] == a[AW-1:IW]) begin
      k = 1;
      tv = mv[p]; trf = mr[p]; tt = mt[p];
      mv[p] = mv[r]; mr[p] = !mr[r]; mt[p] = mt[r];
      mv[r] = tv; mr[r] = !trf; mt[r] = tt;
    end else begin
      k = 2;
      if (mv[p]) begin
        mv[r] = 1'b1; mr[r] = !mr[p]; mt[r] = mt[p];
      end
      mv[p] = 1'b1; mr[p] = 1'b0; mt[p] = a[AW-1:IW];
    end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input string why);
    int exp_k, lat, m0, hold;
    string kt;
    logic [1:0] k0;
    logic [DW-1:0] d0;
    predict(a, exp_k);
    kt = (exp_k == 0) ? "R2" : (exp_k == 1) ? "R3" : "R6";
    cur_addr = a;
    m0 = mem_reqs;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin
      chk(!req_ready, "R7 req_ready low while busy", req_ready, 0);
      @(negedge clk);
      lat++;
    end
    k0 = rsp_kind;
    d0 = rsp_data;
    hold = int'($urandom % 3);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_kind == k0 && rsp_data == d0, "R7 response held", rsp_data, d0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R7 response taken", rsp_valid, 0);
    chk(int'(k0) == exp_k, $sformatf("%s %s kind", why, kt), k0, exp_k);
    chk(d0 == mem_word(a), $sformatf("%s %s data", why, kt), d0, mem_word(a));
    if (exp_k == 0) chk(lat == 1, $sformatf("%s R2 latency", why), lat, 1);
    if (exp_k == 1) chk(lat == 3, $sformatf("%s R3 latency", why), lat, 3);
    chk(mem_reqs - m0 == ((exp_k == 2) ? 1 : 0), $sformatf("%s R6 fetch count", why),
        mem_reqs - m0, (exp_k == 2) ? 1 : 0);
  endtask

  // Memory model: random accept delay, one-word answer after a random wait
  initial begin
    logic [AW-1:0] ma;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (rst_n && mem_req_valid && ($urandom % 3 != 0)) begin
        mem_req_ready = 1'b1;
        mem_reqs++;
        chk(mem_req_addr == cur_addr, "R6 fetch address", mem_req_addr, cur_addr);
        ma = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (int'($urandom % 4)) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_word(ma);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin
      mv[i] = 1'b0; mr[i] = 1'b0; mt[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", mem_req_valid, 0);

    do_req({3'd1, 3'd0}, "R1 first access");
    do_req({3'd1, 3'd0}, "R2 repeat");
    do_req({3'd2, 3'd0}, "R6 conflict fill");
    do_req({3'd1, 3'd4}, "R4 lookalike at partner line");
    do_req({3'd1, 3'd0}, "R8 displaced back home");
    do_req({3'd2, 3'd0}, "R8 evicted block");
    do_req({3'd3, 3'd1}, "R6 fill C");
    do_req({3'd5, 3'd1}, "R6 fill D");
    do_req({3'd3, 3'd1}, "R3 partner hit C");
    do_req({3'd3, 3'd1}, "R5 C after swap");
    do_req({3'd5, 3'd1}, "R5 D after swap");

    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] ra;
      ra = {3'($urandom % 3), 3'($urandom % 8)};
      do_req(ra, "random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule